// File: doc/BRIEF.md
# Request/Acknowledge Handshake Pair with Selectable Interlock

This block holds a master-side and a slave-side controller that pass one transfer event over a two-wire handshake: a request line driven by the master and an acknowledge line driven by the slave. A two-bit mode input chooses how tightly the two sides are coupled. In the loosest discipline each side drops its line after a fixed hold time without looking at the other side. In the middle discipline the master waits for acknowledge before it drops request, while the slave still releases on a timer. In the tightest discipline each side waits for the other side's edge before it releases.

A one-cycle start pulse launches a transfer from the master. Each side issues a one-cycle completion pulse when its part of the exchange ends. Both controllers run on one clock. The mode is captured when the master accepts a start, and the slave adopts the master's captured mode when it sees the request rise. Hold times are parameters counted in clock cycles.

Top module: `hs_link`

## Requirements
- R1: In the cycle after a cycle with reset high, request, acknowledge and both completion pulses are low.
- R2: A start that is sampled high while the master is idle raises request on that same clock edge and captures the mode input. Mode code 0 is loose, 1 is half-coupled, 2 is fully coupled, and 3 behaves as fully coupled.
- R3: In loose mode request stays high for exactly MST_HOLD cycles whatever acknowledge does. The master completion pulse is high for the single cycle that starts when request falls.
- R4: In half-coupled and fully coupled modes the master drops request on the edge after it samples acknowledge high. In half-coupled mode the master completion pulse starts on that same edge.
- R5: The slave raises acknowledge on the edge after it samples a rising request.
- R6: In loose and half-coupled modes the slave keeps acknowledge high for exactly SLV_HOLD cycles, whatever request does, and then drops it. The slave completion pulse starts on the edge where acknowledge falls.
- R7: In fully coupled mode the slave keeps acknowledge high until it samples request low. It then drops acknowledge and issues the slave completion pulse on that edge.
- R8: In fully coupled mode the master completion pulse starts on the edge after the master samples acknowledge low.
- R9: A start sampled while the master is busy is ignored, and so is a change of the mode input during that time. Request and acknowledge keep the timing of the transfer in progress.
- R10: The master returns to idle on the edge that starts its completion pulse. A start sampled on that edge is ignored, and a start sampled on the next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both controllers |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launches a transfer when the master is idle |
| mode_i | input | 2 | Interlock discipline: 0 loose, 1 half-coupled, 2 or 3 fully coupled |
| req_o | output | 1 | Request line driven by the master |
| ack_o | output | 1 | Acknowledge line driven by the slave |
| mst_done_o | output | 1 | One-cycle master completion pulse |
| slv_done_o | output | 1 | One-cycle slave completion pulse |

## Verification
The master's return to idle and a fresh start can fall on the same clock edge. That edge is the one on which the master issues its completion pulse. The bench provokes the collision in loose mode by placing a second start on exactly that edge and, in a separate run, on the edge after it. It then judges the outcome from the line timing: in the first run request must stay low afterwards, and in the second run a complete new handshake must follow. A start and a mode change are also placed inside an active exchange, and the waveforms must match those of the undisturbed transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        LOCK_NONE = 2'd0,
        LOCK_HALF = 2'd1,
        LOCK_FULL = 2'd2,
        LOCK_RSVD = 2'd3
    } lock_t;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_HOLD = 2'd1,
        M_WLOW = 2'd2
    } mst_state_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_t;

    // Reserved code falls back to the safest discipline.
    function automatic lock_t lock_decode(input logic [1:0] code);
        lock_t m;
        case (code)
            2'd0:    m = LOCK_NONE;
            2'd1:    m = LOCK_HALF;
            default: m = LOCK_FULL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hs_hold_timer.sv
module hs_hold_timer #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int unsigned HOLD = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       ack_i,
    output logic       req_o,
    output logic       done_o,
    output lock_t      mode_o
);
    mst_state_t st;
    lock_t      mode_q;
    logic       tmr_run, tmr_exp, release_now;

    assign tmr_run = (st == M_HOLD) && (mode_q == LOCK_NONE);

    hs_hold_timer #(.HOLD(HOLD)) u_tmr (
        .clk(clk), .rst(rst), .run(tmr_run), .expired(tmr_exp)
    );

    assign release_now = (mode_q == LOCK_NONE) ? tmr_exp : ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= M_IDLE;
            req_o  <= 1'b0;
            done_o <= 1'b0;
            mode_q <= LOCK_NONE;
        end else begin
            done_o <= 1'b0;
            case (st)
                M_IDLE: begin
                    if (start_i) begin
                        mode_q <= lock_decode(mode_i);
                        req_o  <= 1'b1;
                        st     <= M_HOLD;
                    end
                end
                M_HOLD: begin
                    if (release_now) begin
                        req_o <= 1'b0;
                        if (mode_q == LOCK_FULL) begin
                            st <= M_WLOW;
                        end else begin
                            done_o <= 1'b1;
                            st     <= M_IDLE;
                        end
                    end
                end
                M_WLOW: begin
                    if (!ack_i) begin
                        done_o <= 1'b1;
                        st     <= M_IDLE;
                    end
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    assign mode_o = mode_q;

    assert_wait_ack_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(req_o) && mode_q != LOCK_NONE) |-> $past(ack_i));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_busy_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (st != M_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
#(
    parameter int unsigned HOLD = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_i,
    input  lock_t mode_i,
    output logic  ack_o,
    output logic  done_o
);
    slv_state_t st;
    lock_t      mode_q;
    logic       req_q, req_rise, pend;
    logic       tmr_run, tmr_exp, release_now;

    assign req_rise = req_i && !req_q;
    assign tmr_run  = (st == S_ACK) && (mode_q != LOCK_FULL);

    hs_hold_timer #(.HOLD(HOLD)) u_tmr (
        .clk(clk), .rst(rst), .run(tmr_run), .expired(tmr_exp)
    );

    assign release_now = (mode_q == LOCK_FULL) ? !req_i : tmr_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ack_o  <= 1'b0;
            done_o <= 1'b0;
            mode_q <= LOCK_NONE;
            req_q  <= 1'b0;
            pend   <= 1'b0;
        end else begin
            req_q  <= req_i;
            done_o <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (req_rise || pend) begin
                        ack_o  <= 1'b1;
                        mode_q <= mode_i;
                        pend   <= 1'b0;
                        st     <= S_ACK;
                    end
                end
                S_ACK: begin
                    // A fresh request arriving during a timed hold is kept.
                    if (req_rise)
                        pend <= 1'b1;
                    if (release_now) begin
                        ack_o  <= 1'b0;
                        done_o <= 1'b1;
                        st     <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assert_full_release_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_o) && mode_q == LOCK_FULL) |-> !$past(req_i));

    assert_ack_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> ($past(req_i) || $past(pend)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !ack_o);

endmodule

// File: rtl/hs_link.sv
module hs_link
    import hs_pkg::*;
#(
    parameter int unsigned MST_HOLD = 4,
    parameter int unsigned SLV_HOLD = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    output logic       req_o,
    output logic       ack_o,
    output logic       mst_done_o,
    output logic       slv_done_o
);
    lock_t act_mode;
    logic  req_w, ack_w;

    hs_master #(.HOLD(MST_HOLD)) u_mst (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .ack_i(ack_w), .req_o(req_w), .done_o(mst_done_o), .mode_o(act_mode)
    );

    hs_slave #(.HOLD(SLV_HOLD)) u_slv (
        .clk(clk), .rst(rst), .req_i(req_w), .mode_i(act_mode),
        .ack_o(ack_w), .done_o(slv_done_o)
    );

    assign req_o = req_w;
    assign ack_o = ack_w;

    assert_reset_lines_R1: assert property (@(posedge clk)
        rst |=> (!req_o && !ack_o && !mst_done_o && !slv_done_o));

endmodule

// File: tb/hs_link_test.sv
module hs_link_test;
    localparam int MD = 4;
    localparam int SD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       req_o, ack_o, mst_done_o, slv_done_o;

    int n_run = 0;
    int n_fail = 0;

    hs_link #(.MST_HOLD(MD), .SLV_HOLD(SD)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .req_o(req_o), .ack_o(ack_o),
        .mst_done_o(mst_done_o), .slv_done_o(slv_done_o)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input int k, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s k=%0d got=%b exp=%b", tag, k, got, exp);
        end
    endtask

    // Edge of the master completion pulse, counted from the accepting edge.
    function automatic int done_edge(input int m);
        if (m == 0) return MD;
        if (m == 1) return 2;
        return 4;
    endfunction

    // sig: 0 req, 1 ack, 2 master done, 3 slave done
    function automatic logic exp_bit(input int m, input int k, input int sig);
        if (k < 0) return 1'b0;
        case (sig)
            0: return (m == 0) ? (k <= MD - 1) : (k <= 1);
            1: return (m >= 2) ? (k >= 1 && k <= 2) : (k >= 1 && k <= SD);
            2: return k == done_edge(m);
            default: return (m >= 2) ? (k == 3) : (k == SD + 1);
        endcase
    endfunction

    function automatic string tag_of(input int m, input int k, input int sig);
        if (sig == 0) return (k == 0) ? "R2" : ((m == 0) ? "R3" : "R4");
        if (sig == 1) return (k == 1) ? "R5" : ((m >= 2) ? "R7" : "R6");
        if (sig == 2) return (m == 0) ? "R3" : ((m == 1) ? "R4" : "R8");
        return (m >= 2) ? "R7" : "R6";
    endfunction

    // m: mode of the transfer; e: edge of an extra start (-1 none); em: its mode
    task automatic run_case(input int m, input int e, input int em, input string xtag);
        logic acc;
        logic [3:0] got;
        acc = (e > done_edge(m));
        @(negedge clk);
        mode_i  = 2'(m);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 16; k++) begin
            got = {slv_done_o, mst_done_o, ack_o, req_o};
            for (int s = 0; s < 4; s++) begin
                logic ex;
                ex = exp_bit(m, k, s) | (acc ? exp_bit(em, k - e, s) : 1'b0);
                check((e < 0) ? tag_of(m, k, s) : xtag, k, got[s], ex);
            end
            if (k + 1 == e) begin
                start_i = 1'b1;
                mode_i  = 2'(em);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: lines idle after reset
        check("R1", 0, req_o, 1'b0);
        check("R1", 0, ack_o, 1'b0);
        check("R1", 0, mst_done_o, 1'b0);
        check("R1", 0, slv_done_o, 1'b0);
        // Sweep every mode code, including reserved 3 acting as fully coupled
        for (int m = 0; m < 4; m++)
            run_case(m, -1, 0, "");
        // R9: start and mode change during a busy exchange are ignored
        run_case(0, 2, 1, "R9");
        run_case(1, 1, 0, "R9");
        run_case(2, 3, 0, "R9");
        // R10: start on the completion edge ignored, one edge later accepted
        run_case(0, MD, 0, "R10");
        run_case(0, MD + 1, 0, "R10");
        run_case(0, MD + 1, 2, "R10");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule